// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, holds them in a request register, filters them through a per-line mask, and raises a single interrupt output toward a CPU. When the CPU acknowledges, the block returns a vector in the same cycle. The vector is a programmable base plus the number of the winning line. Priority is fixed, with line 0 highest. A line is only forwarded when it outranks every line already in service. Software ends service with a specific end-of-interrupt command, or it selects automatic end-of-interrupt at setup.

The CPU reaches the block through two addresses. The command address (`a0`=0) takes the setup start word, the readback selection and the end-of-interrupt commands. A read from it returns the request or in-service register. The data address (`a0`=1) takes the setup words that follow the start word. Outside setup it loads the mask, and a read returns the mask. Setup also selects one of three roles. A single device answers every acknowledge by itself. A cascade master hands the acknowledge of a slave-bearing line to the cascade bus. A cascade slave answers only when the cascade bus carries its own identity. When no eligible request remains at acknowledge time, the block answers with the line-7 vector and leaves in-service bit 7 untouched, which lets software detect a spurious event.

The setup sequencer is a four-state machine. `ST_RUN` is normal operation. `ST_GET_BASE` waits for the vector base. `ST_GET_CASC` waits for the cascade word. `ST_GET_MODE` waits for the mode word. Any command write with bit 4 set moves the machine from any state to `ST_GET_BASE`. From `ST_GET_BASE`, a data write moves it to `ST_GET_CASC` if the device is cascaded. Otherwise it moves to `ST_GET_MODE` if a mode word was announced, and to `ST_RUN` if not. From `ST_GET_CASC`, a data write moves it to `ST_GET_MODE` or `ST_RUN` on the same rule. From `ST_GET_MODE`, a data write returns it to `ST_RUN`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the command-address read returns the request register (0x00 with no inputs high), and `irq_out` is low.
- R2: A command write with bit 4 set (for example 0x11) starts setup. It clears the mask and the in-service register, selects request readback, and turns automatic EOI off. In that word, bit 3=1 means level sensing, bit 1=1 means single device (no cascade word), and bit 0=1 means a mode word follows. The following data writes are taken as the base, then the cascade word if cascaded, then the mode word if announced.
- R3: In edge mode (start-word bit 3=0), a request bit sets on a rising input. It clears when the input falls or when that line is acknowledged, so a line held high does not request again after service. In level mode the request register copies the inputs one clock later.
- R4: Outside setup, a data write loads the mask and a data read returns it. A mask bit of 1 keeps that line from `irq_out` and from acknowledge selection.
- R5: Line 0 has the highest priority. `irq_out` is high exactly when some unmasked pending line has a lower number than every set in-service bit.
- R6: While `inta` is high and the block answers, `vec` equals base plus the winning line number and `vec_oe` is high. The winning in-service bit is set at the next clock, and no other bit is set.
- R7: Command 0x0B selects in-service readback and 0x0A selects request readback at the command address. The selection persists across other operations.
- R8: Command 0x60+n (n=0..7) clears in-service bit n and no other bit.
- R9: With mode-word bit 1 set (automatic EOI), an acknowledge leaves the in-service register unchanged.
- R10: An acknowledge with no eligible line returns base+7 with `vec_oe` high and leaves in-service bit 7 unchanged, even when line 7 is masked.
- R11: As cascade master (start-word bit 1=0 and mode-word bit 2=1, or no mode word), the acknowledge of a line whose bit is set in the cascade word raises `cas_drive` and puts the line number on `cas_out`. `vec_oe` stays low, and the in-service bit for that line is set. The acknowledge of any other line answers with its own vector.
- R12: As cascade slave (mode-word bit 2=0), the block answers an acknowledge only when `cas_in` equals cascade-word bits [2:0]. Otherwise `vec_oe` stays low and the in-service register is unchanged.
- R13: `irq_out` is low while a setup sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Register port select |
| a0 | input | 1 | 0 = command address, 1 = data/mask address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (0 when not reading) |
| ir | input | 8 | Interrupt request inputs |
| irq_out | output | 1 | Interrupt request to the CPU |
| inta | input | 1 | Acknowledge strobe |
| vec | output | 8 | Vector returned during acknowledge |
| vec_oe | output | 1 | This device drives the vector |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_drive | output | 1 | Master hands the acknowledge to a slave |

## Verification
The assertions take for granted that an acknowledge never overlaps a register write. They also take for granted that the CPU does not acknowledge while setup is in progress, because the spurious-vector property reads a low `irq_out` as the absence of an eligible line. The stimulus keeps within both: every write and every acknowledge is a separate one-cycle pulse driven on the falling edge. Each acknowledge follows a completed setup sequence. The sweeps over all request patterns and all mask values use a single-device setup so that cascade selection never hides an answer.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE
    } cfg_state_e;

    typedef enum logic {
        RB_REQ,
        RB_SVC
    } rb_sel_e;

    localparam int unsigned START_BIT   = 4;
    localparam int unsigned LEVEL_BIT   = 3;
    localparam int unsigned SINGLE_BIT  = 1;
    localparam int unsigned NEED4_BIT   = 0;
    localparam int unsigned AEOI_BIT    = 1;
    localparam int unsigned MASTER_BIT  = 2;
    localparam logic [2:0]  EOI_PREFIX  = 3'b011;

endpackage

// File: rtl/pic_cmd_fsm.sv
module pic_cmd_fsm
    import pic_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              a0,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] casc,
    output logic              level_mode,
    output logic              single,
    output logic              aeoi,
    output logic              master,
    output rb_sel_e           rb_sel,
    output logic              init_pulse,
    output logic              eoi_valid,
    output logic [IDX_W-1:0]  eoi_line,
    output logic              busy
);

    cfg_state_e state, state_nx;
    logic       need4;
    logic       cmd_wr, dat_wr, rb_cmd;

    assign cmd_wr     = cs && wr && !a0;
    assign dat_wr     = cs && wr && a0;
    assign init_pulse = cmd_wr && din[START_BIT];
    assign rb_cmd     = cmd_wr && !din[START_BIT] && (din[7:5] == 3'b000)
                        && din[LEVEL_BIT] && din[1];
    assign eoi_valid  = cmd_wr && (din[7:5] == EOI_PREFIX) && !din[START_BIT];
    assign eoi_line   = din[IDX_W-1:0];
    assign busy       = (state != ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (init_pulse) begin
            state_nx = ST_GET_BASE;
        end else if (dat_wr) begin
            unique case (state)
                ST_RUN:      state_nx = ST_RUN;
                ST_GET_BASE: state_nx = !single ? ST_GET_CASC
                                      : (need4 ? ST_GET_MODE : ST_RUN);
                ST_GET_CASC: state_nx = need4 ? ST_GET_MODE : ST_RUN;
                ST_GET_MODE: state_nx = ST_RUN;
                default:     state_nx = ST_RUN;
            endcase
        end
    end

    // configuration and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr        <= '1;
            base       <= '0;
            casc       <= '0;
            level_mode <= 1'b0;
            single     <= 1'b1;
            need4      <= 1'b0;
            aeoi       <= 1'b0;
            master     <= 1'b1;
            rb_sel     <= RB_REQ;
        end else if (init_pulse) begin
            level_mode <= din[LEVEL_BIT];
            single     <= din[SINGLE_BIT];
            need4      <= din[NEED4_BIT];
            aeoi       <= 1'b0;
            master     <= 1'b1;
            imr        <= '0;
            rb_sel     <= RB_REQ;
        end else if (dat_wr) begin
            unique case (state)
                ST_RUN:      imr  <= din;
                ST_GET_BASE: base <= din;
                ST_GET_CASC: casc <= din;
                ST_GET_MODE: begin
                    aeoi   <= din[AEOI_BIT];
                    master <= din[MASTER_BIT];
                end
                default:     imr  <= imr;
            endcase
        end else if (rb_cmd) begin
            rb_sel <= din[0] ? RB_SVC : RB_REQ;
        end
    end

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_mode,
    input  logic [N_LINES-1:0] ir,
    input  logic [N_LINES-1:0] ack_clr,
    output logic [N_LINES-1:0] irr
);

    logic [N_LINES-1:0] ir_d;
    logic [N_LINES-1:0] rise;

    assign rise = ir & ~ir_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_d <= '0;
            irr  <= '0;
        end else begin
            ir_d <= ir;
            if (level_mode) irr <= ir;
            else            irr <= (irr & ir & ~ack_clr) | rise;
        end
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] imr,
    input  logic [N_LINES-1:0] isr,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    logic [N_LINES-1:0] blocked;
    logic [N_LINES-1:0] cand;

    assign blocked[0] = isr[0];
    for (genvar g = 1; g < N_LINES; g++) begin : g_block
        assign blocked[g] = blocked[g-1] | isr[g];
    end

    assign cand = irr & ~imr & ~blocked;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              a0,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [N_LINES-1:0] ir,
    output logic              irq_out,
    input  logic              inta,
    output logic [DATA_W-1:0] vec,
    output logic              vec_oe,
    input  logic [IDX_W-1:0]  cas_in,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_drive
);

    logic [DATA_W-1:0]  imr_w, base, casc;
    logic               level_mode, single, aeoi, master;
    rb_sel_e            rb_sel;
    logic               init_pulse, eoi_valid, busy;
    logic [IDX_W-1:0]   eoi_line;
    logic [N_LINES-1:0] irr, isr, isr_nx, ack_clr;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               responding, master_fwd, set_isr;

    pic_cmd_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .a0         (a0),
        .wr         (wr),
        .din        (din),
        .imr        (imr_w),
        .base       (base),
        .casc       (casc),
        .level_mode (level_mode),
        .single     (single),
        .aeoi       (aeoi),
        .master     (master),
        .rb_sel     (rb_sel),
        .init_pulse (init_pulse),
        .eoi_valid  (eoi_valid),
        .eoi_line   (eoi_line),
        .busy       (busy)
    );

    pic_req_latch #(.N_LINES(N_LINES)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (level_mode),
        .ir         (ir),
        .ack_clr    (ack_clr),
        .irr        (irr)
    );

    pic_arbiter #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_arb (
        .irr       (irr),
        .imr       (imr_w[N_LINES-1:0]),
        .isr       (isr),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // acknowledge handling
    assign responding = inta && (single || master || (cas_in == casc[IDX_W-1:0]));
    assign master_fwd = !single && master && win_valid && casc[win_idx];
    assign set_isr    = responding && win_valid && !aeoi;
    assign ack_clr    = (responding && win_valid) ? (N_LINES'(1) << win_idx) : '0;

    assign irq_out    = win_valid && !busy;
    assign vec_oe     = responding && !master_fwd;
    assign cas_drive  = inta && master_fwd;
    assign cas_out    = win_idx;
    assign vec        = base + (win_valid ? DATA_W'(win_idx) : DATA_W'(N_LINES - 1));

    // in-service register
    always_comb begin
        isr_nx = isr;
        if (eoi_valid) isr_nx[eoi_line] = 1'b0;
        if (set_isr)   isr_nx[win_idx]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          isr <= '0;
        else if (init_pulse) isr <= '0;
        else                 isr <= isr_nx;
    end

    // readback
    always_comb begin
        dout = '0;
        if (cs && rd) begin
            if (a0)                  dout = imr_w;
            else if (rb_sel == RB_SVC) dout = DATA_W'(isr);
            else                     dout = DATA_W'(irr);
        end
    end

endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       a0,
    input logic       wr,
    input logic [7:0] din,
    input logic       inta,
    input logic       irq_out,
    input logic       vec_oe,
    input logic       cas_drive,
    input logic       aeoi,
    input logic [7:0] imr,
    input logic [7:0] isr
);

    logic any_wr;
    assign any_wr = cs && wr;

    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0 && din[4]) |=> (imr == 8'h00 && isr == 8'h00));

    assert_setup_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0 && din[4]) |=> !irq_out);

    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0 && din[7:5] == 3'b011 && !din[4] && !inta)
        |=> !isr[$past(din[2:0])]);

    assert_single_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !any_wr) |=> ($countones(isr & ~$past(isr)) <= 1));

    assert_aeoi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi && !any_wr) |=> (isr == $past(isr)));

    assert_spurious_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && vec_oe && !irq_out && !any_wr) |=> (isr == $past(isr)));

    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |-> (!vec_oe && !cas_drive));

endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .a0        (a0),
    .wr        (wr),
    .din       (din),
    .inta      (inta),
    .irq_out   (irq_out),
    .vec_oe    (vec_oe),
    .cas_drive (cas_drive),
    .aeoi      (aeoi),
    .imr       (imr_w),
    .isr       (isr)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, a0 = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] ir = '0;
    logic       irq_out;
    logic       inta = 1'b0;
    logic [7:0] vec;
    logic       vec_oe;
    logic [2:0] cas_in = '0;
    logic [2:0] cas_out;
    logic       cas_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr), .rd(rd),
        .din(din), .dout(dout), .ir(ir), .irq_out(irq_out), .inta(inta),
        .vec(vec), .vec_oe(vec_oe), .cas_in(cas_in), .cas_out(cas_out),
        .cas_drive(cas_drive)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input bit addr, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; a0 = addr; din = v;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; din = '0;
    endtask

    task automatic rd_reg(input bit addr, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; a0 = addr;
        #1 v = dout;
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v, output logic oe, output logic cd,
                       output logic [2:0] co);
        @(negedge clk);
        inta = 1'b1;
        #1; v = vec; oe = vec_oe; cd = cas_drive; co = cas_out;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic drive_ir(input logic [7:0] v);
        @(negedge clk);
        ir = v;
        @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] w1, input logic [7:0] b,
                         input logic [7:0] w3, input logic [7:0] w4);
        wr_reg(1'b0, w1);
        wr_reg(1'b1, b);
        if (!w1[1]) wr_reg(1'b1, w3);
        if (w1[0])  wr_reg(1'b1, w4);
    endtask

    function automatic int lowest(input logic [7:0] p);
        for (int i = 7; i >= 0; i--) if (p[i]) lowest = i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, v;
        logic oe, cd;
        logic [2:0] co;
        int e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(1'b1, r); chk(r == 8'hFF, "R1 mask", r, 8'hFF);
        rd_reg(1'b0, r); chk(r == 8'h00, "R1 readback", r, 0);
        chk(irq_out == 1'b0, "R1 irq", irq_out, 0);

        // R13 quiet during setup, R2 mask cleared
        wr_reg(1'b0, 8'h13);
        rd_reg(1'b1, r); chk(r == 8'h00, "R2 mask cleared", r, 0);
        drive_ir(8'h01);
        chk(irq_out == 1'b0, "R13 quiet", irq_out, 0);
        wr_reg(1'b1, 8'h40);
        chk(irq_out == 1'b0, "R13 quiet mid", irq_out, 0);
        wr_reg(1'b1, 8'h00);
        chk(irq_out == 1'b1, "R13 released", irq_out, 1);
        drive_ir(8'h00);

        // per-line sweep: R6 R7 R8 R3(edge)
        for (int n = 0; n < 8; n++) begin
            drive_ir(8'(1 << n));
            chk(irq_out == 1'b1, "R5 single line", irq_out, 1);
            ack(v, oe, cd, co);
            chk(v == 8'(8'h40 + n) && oe, "R6 vector", v, 8'h40 + n);
            wr_reg(1'b0, 8'h0B);
            rd_reg(1'b0, r); chk(r == 8'(1 << n), "R7 isr read", r, 1 << n);
            wr_reg(1'b0, 8'h0A);
            rd_reg(1'b0, r); chk(r == 8'h00, "R3 edge ack clears", r, 0);
            wr_reg(1'b0, 8'h0B);
            wr_reg(1'b0, 8'(8'h60 + n));
            rd_reg(1'b0, r); chk(r == 8'h00, "R8 eoi", r, 0);
            chk(irq_out == 1'b0, "R3 edge no re-request", irq_out, 0);
            drive_ir(8'h00);
        end

        // R7 persistence: still reading ISR after other traffic
        rd_reg(1'b0, r); chk(r == 8'h00, "R7 persist", r, 0);

        // R5 exhaustive priority sweep
        for (int p = 1; p < 256; p++) begin
            drive_ir(8'(p));
            e = lowest(8'(p));
            ack(v, oe, cd, co);
            chk(v == 8'(8'h40 + e), "R5 priority", v, 8'h40 + e);
            wr_reg(1'b0, 8'(8'h60 + e));
            drive_ir(8'h00);
        end

        // R5 nesting against ISR, R8 specific clearing
        drive_ir(8'h08);
        ack(v, oe, cd, co);
        drive_ir(8'h28);
        chk(irq_out == 1'b0, "R5 lower blocked", irq_out, 0);
        drive_ir(8'h2A);
        chk(irq_out == 1'b1, "R5 higher passes", irq_out, 1);
        ack(v, oe, cd, co);
        chk(v == 8'h41, "R5 nested vector", v, 8'h41);
        rd_reg(1'b0, r); chk(r == 8'h0A, "R6 nested isr", r, 8'h0A);
        wr_reg(1'b0, 8'h61);
        rd_reg(1'b0, r); chk(r == 8'h08, "R8 only bit 1", r, 8'h08);
        chk(irq_out == 1'b0, "R5 still blocked", irq_out, 0);
        wr_reg(1'b0, 8'h63);
        chk(irq_out == 1'b1, "R5 unblocked", irq_out, 1);
        ack(v, oe, cd, co);
        chk(v == 8'h45, "R5 line5 vector", v, 8'h45);
        wr_reg(1'b0, 8'h65);
        drive_ir(8'h00);

        // R4 exhaustive mask sweep
        for (int m = 0; m < 256; m++) begin
            wr_reg(1'b1, 8'(m));
            rd_reg(1'b1, r);
            chk(r == 8'(m), "R4 mask readback", r, m);
            drive_ir(8'hFF);
            chk(irq_out == (m != 255), "R4 mask irq", irq_out, m != 255);
            if (m != 255) begin
                e = lowest(~8'(m));
                ack(v, oe, cd, co);
                chk(v == 8'(8'h40 + e), "R4 masked selection", v, 8'h40 + e);
                wr_reg(1'b0, 8'(8'h60 + e));
            end
            drive_ir(8'h00);
        end

        // R10 spurious: request vanishes, then with line 7 masked
        wr_reg(1'b1, 8'h00);
        drive_ir(8'h10);
        drive_ir(8'h00);
        ack(v, oe, cd, co);
        chk(v == 8'h47 && oe, "R10 spurious vector", v, 8'h47);
        rd_reg(1'b0, r); chk(r == 8'h00, "R10 isr7 clear", r, 0);
        wr_reg(1'b1, 8'hFF);
        ack(v, oe, cd, co);
        chk(v == 8'h47 && oe, "R10 masked spurious", v, 8'h47);
        rd_reg(1'b0, r); chk(r == 8'h00, "R10 masked isr7", r, 0);

        // R3 level mode
        setup(8'h1B, 8'h20, 8'h00, 8'h00);
        drive_ir(8'h04);
        ack(v, oe, cd, co);
        chk(v == 8'h22, "R3 level vector", v, 8'h22);
        chk(irq_out == 1'b0, "R3 level in service", irq_out, 0);
        wr_reg(1'b0, 8'h62);
        chk(irq_out == 1'b1, "R3 level re-request", irq_out, 1);
        rd_reg(1'b0, r); chk(r == 8'h04, "R3 level irr", r, 8'h04);
        drive_ir(8'h00);
        chk(irq_out == 1'b0, "R3 level drop", irq_out, 0);

        // R9 automatic EOI
        setup(8'h13, 8'h48, 8'h00, 8'h02);
        wr_reg(1'b0, 8'h0B);
        drive_ir(8'h40);
        ack(v, oe, cd, co);
        chk(v == 8'h4E && oe, "R9 vector", v, 8'h4E);
        rd_reg(1'b0, r); chk(r == 8'h00, "R9 isr untouched", r, 0);
        drive_ir(8'h00);

        // R11 cascade master
        setup(8'h11, 8'h08, 8'h04, 8'h04);
        wr_reg(1'b0, 8'h0B);
        drive_ir(8'h04);
        ack(v, oe, cd, co);
        chk(cd == 1'b1 && oe == 1'b0, "R11 forwarded", {cd, oe}, 2'b10);
        chk(co == 3'd2, "R11 cas id", co, 2);
        rd_reg(1'b0, r); chk(r == 8'h04, "R11 isr", r, 8'h04);
        wr_reg(1'b0, 8'h62);
        drive_ir(8'h08);
        ack(v, oe, cd, co);
        chk(v == 8'h0B && oe && !cd, "R11 own line", v, 8'h0B);
        wr_reg(1'b0, 8'h63);
        drive_ir(8'h00);

        // R12 cascade slave
        setup(8'h11, 8'h70, 8'h02, 8'h00);
        wr_reg(1'b0, 8'h0B);
        drive_ir(8'h10);
        cas_in = 3'd3;
        ack(v, oe, cd, co);
        chk(oe == 1'b0, "R12 other id", oe, 0);
        rd_reg(1'b0, r); chk(r == 8'h00, "R12 isr unchanged", r, 0);
        chk(irq_out == 1'b1, "R12 still pending", irq_out, 1);
        cas_in = 3'd2;
        ack(v, oe, cd, co);
        chk(v == 8'h74 && oe, "R12 own id", v, 8'h74);
        rd_reg(1'b0, r); chk(r == 8'h10, "R12 isr set", r, 8'h10);
        drive_ir(8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule